// File: doc/BRIEF.md
# Store Queue Commit and Writeback Engine

This block holds executed stores of an out-of-order core (sequence number, address, size, data and attribute bits) in an age-ordered circular buffer. A commit pulse carrying a sequence number marks the older stores as allowed to write back. The engine then drains the eligible stores to a data-cache request interface of `NPORTS` lanes, oldest first. Completions are reported back to the commit logic.

Two kinds of store need no cache access. A store with size zero completes without a request. A store-conditional that finds no lock reservation also completes without a request. A store-conditional that does reach the cache is held until the cache sends a response, and it then reports a result code. When the cache refuses a request, the engine stalls until the cache signals that it may retry. A squash removes uncommitted stores from the young end of the buffer.

Top module: `store_queue`

## Requirements
- R1: After reset the buffer is empty: `free_cnt` equals DEPTH, `pend_cnt` is 0, `store_blocked` is 0, no `req_valid` or `done_valid` bit is set, and `ins_ready` is 1.
- R2: `free_cnt` equals DEPTH minus the occupied slots. An accepted store stays in its slot until its response arrives. `ins_ready` is 0 when `free_cnt` is 0, and an insert is accepted only when `ins_valid` and `ins_ready` are both 1.
- R3: A commit pulse walks the stores from oldest to youngest. Each store with a sequence number at or below `cmt_seq` that is not yet eligible becomes eligible and adds one to `pend_cnt`. The walk stops at the first store whose sequence number is above `cmt_seq`. A store that is not eligible never produces a request.
- R4: A store-conditional inserted with `ins_fault` at 0 is eligible from insertion and adds one to `pend_cnt`. With `ins_fault` at 1 it waits for commit like an ordinary store.
- R5: In each cycle that is not blocked, up to NPORTS eligible stores are presented in age order, with lane 0 the oldest. Presentation stops at the first valid store that is not eligible. Stores already sent are passed over.
- R6: The cache accepts lanes in prefix order. A presented lane with `req_ready` at 0 sets `store_blocked`. While blocked, no lane is valid. A `cache_retry` pulse clears the flag, and the refused store is presented again on lane 0.
- R7: An eligible store of size zero completes on `done_valid` with `req_valid` at 0 on its lane, and it frees its slot.
- R8: An eligible prefetch-only entry is removed with no request and no completion. `pend_cnt` drops by one.
- R9: A store-conditional result is 2 when the store is uncacheable, 1 when `lock_flag` is set, and 0 otherwise. A result of 0 completes at once on `done_valid` with `done_cond` at 1 and no request. Results 1 and 2 issue a request with `req_cond` at 1. They report on `rdone_valid`/`rdone_res` when `rsp_valid` returns with that request's tag.
- R10: An ordinary store reports `done_valid` with its sequence number in the same cycle its request is accepted, and it frees its slot.
- R11: A squash removes stores from the young end while their sequence number is above `sqh_seq`. It stops at the first store that is already eligible. `ins_ready` is 0 during a squash.
- R12: `pend_cnt` drops by one for every completion: a done lane, a response or a removed prefetch-only entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert an executed store |
| ins_ready | output | 1 | Insert can be accepted |
| ins_seq | input | SEQ_W | Sequence number of the inserted store |
| ins_addr | input | ADDR_W | Store address |
| ins_size | input | SIZE_W | Store size in bytes; 0 means no access |
| ins_data | input | DATA_W | Store data |
| ins_cond | input | 1 | Store-conditional |
| ins_uncached | input | 1 | Uncacheable store |
| ins_prefetch | input | 1 | Prefetch-only entry |
| ins_fault | input | 1 | Execute raised a fault |
| cmt_valid | input | 1 | Commit pulse |
| cmt_seq | input | SEQ_W | Youngest committed sequence number |
| sqh_valid | input | 1 | Squash pulse |
| sqh_seq | input | SEQ_W | Stores younger than this are squashed |
| lock_flag | input | 1 | Lock reservation held |
| req_valid | output | NPORTS | Request valid per lane |
| req_ready | input | NPORTS | Cache accepts lane (prefix form) |
| req_addr | output | NPORTS x ADDR_W | Request address per lane |
| req_data | output | NPORTS x DATA_W | Request data per lane |
| req_size | output | NPORTS x SIZE_W | Request size per lane |
| req_cond | output | NPORTS | Request is a store-conditional |
| req_tag | output | NPORTS x log2(DEPTH) | Slot tag returned with the response |
| cache_retry | input | 1 | Cache can take requests again |
| rsp_valid | input | 1 | Response for a store-conditional |
| rsp_tag | input | log2(DEPTH) | Tag of the response |
| done_valid | output | NPORTS | Completion at issue, per lane |
| done_seq | output | NPORTS x SEQ_W | Sequence number of the completion |
| done_cond | output | NPORTS | Completion is a failed store-conditional |
| rdone_valid | output | 1 | Completion from a response |
| rdone_seq | output | SEQ_W | Sequence number of that completion |
| rdone_res | output | 2 | Store-conditional result code |
| store_blocked | output | 1 | Writeback stalled by a refusal |
| pend_cnt | output | log2(DEPTH+1) | Eligible stores not yet complete |
| free_cnt | output | log2(DEPTH+1) | Free slots |

## Verification
The hardest case is a squash that arrives while eligible stores are still waiting behind a refused request. Only then can the squash meet an eligible store that is younger than the squash number and must stop there. The bench holds `req_ready` low so that the oldest store is refused and the engine blocks. It then commits a second store and squashes below it. It checks that only the two youngest uncommitted stores are removed. After the retry, exactly the two surviving stores must drain. A second hard case puts a store-conditional that became eligible at insertion behind an uncommitted ordinary store. It checks that nothing issues until that older store commits.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {
    SC_FAIL     = 2'd0,
    SC_LOCKED   = 2'd1,
    SC_UNCACHED = 2'd2
  } sc_res_e;
endpackage

// File: rtl/sq_commit_mark.sv
module sq_commit_mark #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int CW    = 4
) (
  input  logic             en,
  input  logic [SEQ_W-1:0] cmt_seq,
  input  logic [DEPTH-1:0] vld,
  input  logic [DEPTH-1:0] elig,
  input  logic [SEQ_W-1:0] seq [DEPTH],
  output logic [DEPTH-1:0] mark,
  output logic [CW-1:0]    n_mark
);
  always_comb begin
    int  cnt;
    logic stop;
    cnt  = 0;
    stop = 1'b0;
    mark = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (en && !stop && vld[i]) begin
        if (seq[i] > cmt_seq) begin
          stop = 1'b1;
        end else if (!elig[i]) begin
          mark[i] = 1'b1;
          cnt     = cnt + 1;
        end
      end
    end
    n_mark = CW'(cnt);
  end
endmodule

// File: rtl/sq_squash.sv
module sq_squash #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int PW    = 4,
  parameter int CW    = 4
) (
  input  logic             en,
  input  logic [SEQ_W-1:0] sqh_seq,
  input  logic [PW-1:0]    occ,
  input  logic [DEPTH-1:0] vld,
  input  logic [DEPTH-1:0] elig,
  input  logic [SEQ_W-1:0] seq [DEPTH],
  output logic [DEPTH-1:0] kill,
  output logic [CW-1:0]    n_back
);
  always_comb begin
    int   back;
    logic stop;
    back = 0;
    stop = 1'b0;
    kill = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (en && !stop && (i < int'(occ))) begin
        if (!vld[i]) begin
          back = back + 1;
        end else if ((seq[i] > sqh_seq) && !elig[i]) begin
          kill[i] = 1'b1;
          back    = back + 1;
        end else begin
          stop = 1'b1;
        end
      end
    end
    n_back = CW'(back);
  end
endmodule

// File: rtl/sq_wb_select.sv
module sq_wb_select #(
  parameter int DEPTH  = 8,
  parameter int NPORTS = 2,
  parameter int IW     = 3,
  parameter int CW     = 4
) (
  input  logic             en,
  input  logic [DEPTH-1:0] vld,
  input  logic [DEPTH-1:0] elig,
  input  logic [DEPTH-1:0] sent,
  input  logic [DEPTH-1:0] pf,
  output logic [NPORTS-1:0] lane_vld,
  output logic [IW-1:0]     lane_age [NPORTS],
  output logic [DEPTH-1:0]  drop,
  output logic [CW-1:0]     n_drop
);
  always_comb begin
    int   used;
    int   nd;
    logic stop;
    used     = 0;
    nd       = 0;
    stop     = 1'b0;
    lane_vld = '0;
    drop     = '0;
    for (int k = 0; k < NPORTS; k++) lane_age[k] = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (en && !stop && vld[i]) begin
        if (!elig[i]) begin
          stop = 1'b1;
        end else if (sent[i]) begin
          stop = stop;
        end else if (pf[i]) begin
          drop[i] = 1'b1;
          nd      = nd + 1;
        end else if (used < NPORTS) begin
          lane_vld[used] = 1'b1;
          lane_age[used] = IW'(i);
          used           = used + 1;
        end else begin
          stop = 1'b1;
        end
      end
    end
    n_drop = CW'(nd);
  end
endmodule

// File: rtl/store_queue.sv
module store_queue
  import sq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NPORTS = 2,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 4,
  localparam int IW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              ins_valid,
  output logic                              ins_ready,
  input  logic [SEQ_W-1:0]                  ins_seq,
  input  logic [ADDR_W-1:0]                 ins_addr,
  input  logic [SIZE_W-1:0]                 ins_size,
  input  logic [DATA_W-1:0]                 ins_data,
  input  logic                              ins_cond,
  input  logic                              ins_uncached,
  input  logic                              ins_prefetch,
  input  logic                              ins_fault,
  input  logic                              cmt_valid,
  input  logic [SEQ_W-1:0]                  cmt_seq,
  input  logic                              sqh_valid,
  input  logic [SEQ_W-1:0]                  sqh_seq,
  input  logic                              lock_flag,
  output logic [NPORTS-1:0]                 req_valid,
  input  logic [NPORTS-1:0]                 req_ready,
  output logic [NPORTS-1:0][ADDR_W-1:0]     req_addr,
  output logic [NPORTS-1:0][DATA_W-1:0]     req_data,
  output logic [NPORTS-1:0][SIZE_W-1:0]     req_size,
  output logic [NPORTS-1:0]                 req_cond,
  output logic [NPORTS-1:0][IW-1:0]         req_tag,
  input  logic                              cache_retry,
  input  logic                              rsp_valid,
  input  logic [IW-1:0]                     rsp_tag,
  output logic [NPORTS-1:0]                 done_valid,
  output logic [NPORTS-1:0][SEQ_W-1:0]      done_seq,
  output logic [NPORTS-1:0]                 done_cond,
  output logic                              rdone_valid,
  output logic [SEQ_W-1:0]                  rdone_seq,
  output logic [1:0]                        rdone_res,
  output logic                              store_blocked,
  output logic [CW-1:0]                     pend_cnt,
  output logic [CW-1:0]                     free_cnt
);
  localparam int PW = IW + 1;

  // slot state, control part (reset)
  logic [DEPTH-1:0] vld_q, elig_q, sent_q;
  logic [DEPTH-1:0] vld_n, elig_n, sent_n;
  logic [PW-1:0]    head_q, tail_q, head_n, tail_n;
  logic [CW-1:0]    pend_q, pend_n;
  logic             blk_q, blk_n;

  // slot state, data part (no reset)
  logic [DEPTH-1:0]  cond_q, uc_q, pf_q;
  logic [SEQ_W-1:0]  seq_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [SIZE_W-1:0] size_q [DEPTH];
  logic [1:0]        res_q  [DEPTH];
  logic [DEPTH-1:0]  res_we;
  logic [1:0]        res_wd [DEPTH];

  // age-ordered views
  logic [IW-1:0]     age_slot [DEPTH];
  logic [DEPTH-1:0]  a_vld, a_elig, a_sent, a_pf, a_elig_c;
  logic [SEQ_W-1:0]  a_seq [DEPTH];
  logic [DEPTH-1:0]  a_mark, a_kill, a_drop;
  logic [CW-1:0]     n_mark, n_back, n_drop;
  logic [PW-1:0]     occ;

  // lanes
  logic [NPORTS-1:0] lane_vld;
  logic [IW-1:0]     lane_age [NPORTS];
  logic [IW-1:0]     l_slot   [NPORTS];
  sc_res_e           l_res    [NPORTS];
  logic [NPORTS-1:0] l_req, l_go, l_hold;
  logic              reject;
  logic              ins_fire, rsp_fire;
  logic [IW-1:0]     tail_slot;

  assign occ       = tail_q - head_q;
  assign free_cnt  = CW'(DEPTH) - CW'(occ);
  assign ins_ready = (free_cnt != '0) && !sqh_valid;
  assign ins_fire  = ins_valid && ins_ready;
  assign tail_slot = tail_q[IW-1:0];
  assign rsp_fire  = rsp_valid && vld_q[rsp_tag] && sent_q[rsp_tag];

  assign pend_cnt      = pend_q;
  assign store_blocked = blk_q;
  assign rdone_valid   = rsp_fire;
  assign rdone_seq     = seq_q[rsp_tag];
  assign rdone_res     = res_q[rsp_tag];

  for (genvar g = 0; g < DEPTH; g++) begin : g_age
    assign age_slot[g] = head_q[IW-1:0] + IW'(g);
    assign a_vld[g]    = vld_q[age_slot[g]];
    assign a_elig[g]   = elig_q[age_slot[g]];
    assign a_sent[g]   = sent_q[age_slot[g]];
    assign a_pf[g]     = pf_q[age_slot[g]];
    assign a_seq[g]    = seq_q[age_slot[g]];
  end

  assign a_elig_c = a_elig | a_mark;

  sq_commit_mark #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .CW(CW)) u_mark (
    .en(cmt_valid), .cmt_seq(cmt_seq), .vld(a_vld), .elig(a_elig),
    .seq(a_seq), .mark(a_mark), .n_mark(n_mark)
  );

  sq_squash #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .PW(PW), .CW(CW)) u_squash (
    .en(sqh_valid), .sqh_seq(sqh_seq), .occ(occ), .vld(a_vld),
    .elig(a_elig_c), .seq(a_seq), .kill(a_kill), .n_back(n_back)
  );

  sq_wb_select #(.DEPTH(DEPTH), .NPORTS(NPORTS), .IW(IW), .CW(CW)) u_select (
    .en(!blk_q), .vld(a_vld), .elig(a_elig), .sent(a_sent), .pf(a_pf),
    .lane_vld(lane_vld), .lane_age(lane_age), .drop(a_drop), .n_drop(n_drop)
  );

  // per-lane decode
  for (genvar k = 0; k < NPORTS; k++) begin : g_lane
    assign l_slot[k] = head_q[IW-1:0] + lane_age[k];
    assign l_res[k]  = uc_q[l_slot[k]] ? SC_UNCACHED :
                       (lock_flag ? SC_LOCKED : SC_FAIL);
    assign l_req[k]  = lane_vld[k] && (size_q[l_slot[k]] != '0) &&
                       (!cond_q[l_slot[k]] || (l_res[k] != SC_FAIL));
    assign l_hold[k] = l_go[k] && l_req[k] && cond_q[l_slot[k]];

    assign req_valid[k]  = l_req[k];
    assign req_addr[k]   = addr_q[l_slot[k]];
    assign req_data[k]   = data_q[l_slot[k]];
    assign req_size[k]   = size_q[l_slot[k]];
    assign req_cond[k]   = cond_q[l_slot[k]];
    assign req_tag[k]    = l_slot[k];
    assign done_valid[k] = l_go[k] && !l_hold[k];
    assign done_seq[k]   = seq_q[l_slot[k]];
    assign done_cond[k]  = cond_q[l_slot[k]];
  end

  // in-order acceptance: a lane takes effect only if every older request lane was taken
  always_comb begin
    logic ok;
    ok     = 1'b1;
    reject = 1'b0;
    l_go   = '0;
    for (int k = 0; k < NPORTS; k++) begin
      l_go[k] = lane_vld[k] && ok && (!l_req[k] || req_ready[k]);
      if (l_req[k] && ok && !req_ready[k]) reject = 1'b1;
      ok = ok && (!l_req[k] || req_ready[k]);
    end
  end

  // next state
  always_comb begin
    int   n_done;
    int   adv;
    int   ins_sc;
    logic stop;
    logic [PW-1:0] occ_n;
    vld_n  = vld_q;
    elig_n = elig_q;
    sent_n = sent_q;
    res_we = '0;
    for (int s = 0; s < DEPTH; s++) res_wd[s] = SC_FAIL;
    n_done = 0;

    for (int a = 0; a < DEPTH; a++) begin
      if (a_mark[a]) elig_n[age_slot[a]] = 1'b1;
      if (a_drop[a] || a_kill[a]) vld_n[age_slot[a]] = 1'b0;
    end

    for (int k = 0; k < NPORTS; k++) begin
      if (l_hold[k]) begin
        sent_n[l_slot[k]] = 1'b1;
        res_we[l_slot[k]] = 1'b1;
        res_wd[l_slot[k]] = l_res[k];
      end else if (l_go[k]) begin
        vld_n[l_slot[k]] = 1'b0;
        n_done = n_done + 1;
      end
    end

    if (rsp_fire) vld_n[rsp_tag] = 1'b0;

    ins_sc = 0;
    if (ins_fire) begin
      vld_n[tail_slot]  = 1'b1;
      elig_n[tail_slot] = ins_cond && !ins_fault;
      sent_n[tail_slot] = 1'b0;
      ins_sc = (ins_cond && !ins_fault) ? 1 : 0;
    end

    tail_n = tail_q - PW'(n_back) + PW'(ins_fire);
    occ_n  = tail_n - head_q;
    adv    = 0;
    stop   = 1'b0;
    for (int a = 0; a < DEPTH; a++) begin
      if (!stop && (a < int'(occ_n)) && !vld_n[age_slot[a]]) adv = adv + 1;
      else stop = 1'b1;
    end
    head_n = head_q + PW'(adv);

    pend_n = CW'(int'(pend_q) + int'(n_mark) + ins_sc - n_done
                 - int'(n_drop) - int'(rsp_fire));
    blk_n  = blk_q ? !cache_retry : reject;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      elig_q <= '0;
      sent_q <= '0;
      head_q <= '0;
      tail_q <= '0;
      pend_q <= '0;
      blk_q  <= 1'b0;
    end else begin
      vld_q  <= vld_n;
      elig_q <= elig_n;
      sent_q <= sent_n;
      head_q <= head_n;
      tail_q <= tail_n;
      pend_q <= pend_n;
      blk_q  <= blk_n;
    end
  end

  // payload registers with explicit write enables
  always_ff @(posedge clk) begin
    for (int s = 0; s < DEPTH; s++) begin
      if (ins_fire && (tail_slot == IW'(s))) begin
        seq_q[s]  <= ins_seq;
        addr_q[s] <= ins_addr;
        data_q[s] <= ins_data;
        size_q[s] <= ins_size;
        cond_q[s] <= ins_cond;
        uc_q[s]   <= ins_uncached;
        pf_q[s]   <= ins_prefetch;
      end
      if (res_we[s]) res_q[s] <= res_wd[s];
    end
  end
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int DEPTH  = 8,
  parameter int NPORTS = 2,
  parameter int CW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_ready,
  input logic              sqh_valid,
  input logic [NPORTS-1:0] req_valid,
  input logic [NPORTS-1:0] req_ready,
  input logic              rdone_valid,
  input logic [1:0]        rdone_res,
  input logic              store_blocked,
  input logic [CW-1:0]     pend_cnt,
  input logic [CW-1:0]     free_cnt
);
  // R6
  blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_blocked |-> (req_valid == '0));

  // R6
  blocked_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(store_blocked) |-> $past(|(req_valid & ~req_ready)));

  // R2
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt == '0) |-> !ins_ready);

  // R11
  squash_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sqh_valid |-> !ins_ready);

  // R9
  rdone_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdone_valid |-> ((rdone_res == 2'd1) || (rdone_res == 2'd2)));

  // R12
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pend_cnt) <= DEPTH) && (int'(free_cnt) <= DEPTH));
endmodule

bind store_queue sq_checker #(.DEPTH(DEPTH), .NPORTS(NPORTS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_ready(ins_ready), .sqh_valid(sqh_valid),
  .req_valid(req_valid), .req_ready(req_ready), .rdone_valid(rdone_valid),
  .rdone_res(rdone_res), .store_blocked(store_blocked), .pend_cnt(pend_cnt),
  .free_cnt(free_cnt)
);

// File: tb/tb_store_queue.sv
`timescale 1ns/1ps
module tb_store_queue;
  localparam int DEPTH = 8, NP = 2, SW = 16, AW = 32, DW = 32, ZW = 4;
  localparam int IW = 3, CW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic ins_valid, ins_ready, ins_cond, ins_uncached, ins_prefetch, ins_fault;
  logic [SW-1:0] ins_seq, cmt_seq, sqh_seq, rdone_seq;
  logic [AW-1:0] ins_addr;
  logic [ZW-1:0] ins_size;
  logic [DW-1:0] ins_data;
  logic cmt_valid, sqh_valid, lock_flag, cache_retry, rsp_valid, rdone_valid;
  logic [NP-1:0] req_valid, req_ready, req_cond, done_valid, done_cond;
  logic [NP-1:0][AW-1:0] req_addr;
  logic [NP-1:0][DW-1:0] req_data;
  logic [NP-1:0][ZW-1:0] req_size;
  logic [NP-1:0][IW-1:0] req_tag;
  logic [NP-1:0][SW-1:0] done_seq;
  logic [IW-1:0] rsp_tag;
  logic [1:0] rdone_res;
  logic store_blocked;
  logic [CW-1:0] pend_cnt, free_cnt;

  int n_checks = 0;
  int n_fail   = 0;
  logic [IW-1:0] tg;

  always #2 clk = ~clk;

  store_queue dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_seq(ins_seq), .ins_addr(ins_addr), .ins_size(ins_size), .ins_data(ins_data),
    .ins_cond(ins_cond), .ins_uncached(ins_uncached), .ins_prefetch(ins_prefetch),
    .ins_fault(ins_fault), .cmt_valid(cmt_valid), .cmt_seq(cmt_seq),
    .sqh_valid(sqh_valid), .sqh_seq(sqh_seq), .lock_flag(lock_flag),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_data(req_data), .req_size(req_size), .req_cond(req_cond), .req_tag(req_tag),
    .cache_retry(cache_retry), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
    .done_valid(done_valid), .done_seq(done_seq), .done_cond(done_cond),
    .rdone_valid(rdone_valid), .rdone_seq(rdone_seq), .rdone_res(rdone_res),
    .store_blocked(store_blocked), .pend_cnt(pend_cnt), .free_cnt(free_cnt)
  );

  task automatic chk(input string r, input longint act, input longint exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic ins(input int sq, input int sz, input bit c, input bit uc,
                     input bit pf, input bit flt);
    @(negedge clk);
    ins_valid = 1'b1; ins_seq = SW'(sq); ins_addr = AW'(32'h1000 + sq * 16);
    ins_size = ZW'(sz); ins_data = DW'(32'hD000 + sq); ins_cond = c;
    ins_uncached = uc; ins_prefetch = pf; ins_fault = flt;
    @(negedge clk);
    ins_valid = 1'b0; ins_cond = 1'b0; ins_uncached = 1'b0;
    ins_prefetch = 1'b0; ins_fault = 1'b0;
    #1;
  endtask

  task automatic commit(input int sq);
    @(negedge clk);
    cmt_valid = 1'b1; cmt_seq = SW'(sq);
    @(negedge clk);
    cmt_valid = 1'b0;
    #1;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic respond(input logic [IW-1:0] t, input int sq, input int res);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_tag = t;
    #1;
    chk("R9 rdone_valid", rdone_valid, 1);
    chk("R9 rdone_seq", rdone_seq, sq);
    chk("R9 rdone_res", rdone_res, res);
    @(negedge clk);
    rsp_valid = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk("R1 free", free_cnt, DEPTH);
    chk("R1 pend", pend_cnt, 0);
    chk("R1 blocked", store_blocked, 0);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 done_valid", done_valid, 0);
    chk("R1 ins_ready", ins_ready, 1);
  endtask

  task automatic t_commit_order();
    ins(10, 8, 0, 0, 0, 0); ins(11, 8, 0, 0, 0, 0); ins(12, 4, 0, 0, 0, 0);
    chk("R3 no req before commit", req_valid, 0);
    chk("R2 free after 3", free_cnt, 5);
    commit(11);
    chk("R3 pend after commit", pend_cnt, 2);
    chk("R5 lanes", req_valid, 2'b11);
    chk("R5 lane0 oldest", req_addr[0], 32'h1000 + 10 * 16);
    chk("R5 lane1 next", req_addr[1], 32'h1000 + 11 * 16);
    chk("R5 lane0 data", req_data[0], 32'hD000 + 10);
    chk("R10 done at accept", done_valid, 2'b11);
    chk("R10 done seq0", done_seq[0], 10);
    chk("R10 done seq1", done_seq[1], 11);
    chk("R10 done_cond", done_cond, 0);
    step();
    chk("R12 pend after done", pend_cnt, 0);
    chk("R3 younger waits", req_valid, 0);
    chk("R2 free after drain", free_cnt, 7);
    commit(12);
    chk("R3 later commit", req_valid, 2'b01);
    chk("R3 lane0 size", req_size[0], 4);
    step();
    chk("R2 empty again", free_cnt, 8);
  endtask

  task automatic t_ports();
    ins(20, 8, 0, 0, 0, 0); ins(21, 8, 0, 0, 0, 0); ins(22, 8, 0, 0, 0, 0);
    commit(22);
    chk("R5 two lanes max", req_valid, 2'b11);
    chk("R5 lane1 seq", done_seq[1], 21);
    step();
    chk("R5 third next cycle", req_valid, 2'b01);
    chk("R5 third seq", done_seq[0], 22);
    step();
    chk("R12 pend zero", pend_cnt, 0);
  endtask

  task automatic t_blocked();
    req_ready = 2'b00;
    ins(30, 8, 0, 0, 0, 0);
    commit(30);
    chk("R6 presented", req_valid, 2'b01);
    chk("R6 no done when refused", done_valid, 0);
    step();
    chk("R6 blocked set", store_blocked, 1);
    chk("R6 quiet", req_valid, 0);
    step();
    chk("R6 still blocked", store_blocked, 1);
    @(negedge clk);
    cache_retry = 1'b1; req_ready = 2'b11;
    @(negedge clk);
    cache_retry = 1'b0;
    #1;
    chk("R6 unblocked", store_blocked, 0);
    chk("R6 re-presented", req_addr[0], 32'h1000 + 30 * 16);
    chk("R6 done on retry", done_valid, 2'b01);
    step();
    chk("R12 pend after retry", pend_cnt, 0);
  endtask

  task automatic t_zero_pf();
    ins(50, 0, 0, 0, 0, 0);
    commit(50);
    chk("R7 no request", req_valid, 0);
    chk("R7 done", done_valid, 2'b01);
    chk("R7 done seq", done_seq[0], 50);
    step();
    chk("R7 freed", free_cnt, 8);
    ins(60, 8, 0, 0, 1, 0);
    commit(60);
    chk("R8 pend marked", pend_cnt, 1);
    chk("R8 no request", req_valid, 0);
    chk("R8 no done", done_valid, 0);
    step();
    chk("R8 pend dropped", pend_cnt, 0);
    chk("R8 freed", free_cnt, 8);
  endtask

  task automatic t_sc();
    lock_flag = 1'b0;
    ins(70, 8, 1, 0, 0, 0);
    chk("R4 eligible at insert", pend_cnt, 1);
    chk("R9 fail no request", req_valid, 0);
    chk("R9 fail done", done_valid, 2'b01);
    chk("R9 fail cond flag", done_cond[0], 1);
    step();
    chk("R12 pend after fail", pend_cnt, 0);
    lock_flag = 1'b1;
    ins(71, 8, 1, 0, 0, 0);
    chk("R9 locked request", req_valid, 2'b01);
    chk("R9 req_cond", req_cond[0], 1);
    tg = req_tag[0];
    step();
    chk("R2 in flight holds slot", free_cnt, 7);
    chk("R9 waits for response", pend_cnt, 1);
    chk("R5 sent passed over", req_valid, 0);
    respond(tg, 71, 1);
    chk("R12 pend after rsp", pend_cnt, 0);
    chk("R2 freed after rsp", free_cnt, 8);
    ins(72, 8, 1, 1, 0, 0);
    chk("R9 uncached request", req_valid, 2'b01);
    tg = req_tag[0];
    step();
    respond(tg, 72, 2);
    lock_flag = 1'b0;
    ins(73, 8, 1, 0, 0, 1);
    chk("R4 faulted waits", pend_cnt, 0);
    chk("R4 faulted no done", done_valid, 0);
    commit(73);
    chk("R4 faulted after commit", done_valid, 2'b01);
    step();
  endtask

  task automatic t_stop();
    lock_flag = 1'b1;
    ins(80, 8, 0, 0, 0, 0);
    ins(81, 8, 1, 0, 0, 0);
    chk("R5 stops at uncommitted", req_valid, 0);
    chk("R4 sc pending", pend_cnt, 1);
    commit(80);
    chk("R5 both after commit", req_valid, 2'b11);
    chk("R5 lane0 older", req_addr[0], 32'h1000 + 80 * 16);
    chk("R5 lane1 sc", req_cond[1], 1);
    chk("R10 only ordinary done", done_valid, 2'b01);
    tg = req_tag[1];
    step();
    chk("R12 pend one left", pend_cnt, 1);
    respond(tg, 81, 1);
    chk("R12 pend zero", pend_cnt, 0);
    lock_flag = 1'b0;
  endtask

  task automatic t_squash();
    req_ready = 2'b00;
    ins(90, 8, 0, 0, 0, 0); ins(91, 8, 0, 0, 0, 0);
    ins(92, 8, 0, 0, 0, 0); ins(93, 8, 0, 0, 0, 0);
    chk("R2 free four", free_cnt, 4);
    commit(90);
    commit(91);
    chk("R6 blocked before squash", store_blocked, 1);
    chk("R3 pend two", pend_cnt, 2);
    @(negedge clk);
    sqh_valid = 1'b1; sqh_seq = SW'(90);
    #1;
    chk("R11 insert refused", ins_ready, 0);
    @(negedge clk);
    sqh_valid = 1'b0;
    #1;
    chk("R11 stopped at eligible", free_cnt, 6);
    @(negedge clk);
    cache_retry = 1'b1; req_ready = 2'b11;
    @(negedge clk);
    cache_retry = 1'b0;
    #1;
    chk("R11 survivors issue", req_valid, 2'b11);
    chk("R11 survivor seq", done_seq[1], 91);
    step();
    chk("R11 nothing left", req_valid, 0);
    chk("R11 empty", free_cnt, 8);
    chk("R12 pend zero", pend_cnt, 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) ins(100 + i, 8, 0, 0, 0, 0);
    chk("R2 full", free_cnt, 0);
    chk("R2 ready low", ins_ready, 0);
    @(negedge clk);
    sqh_valid = 1'b1; sqh_seq = SW'(99);
    @(negedge clk);
    sqh_valid = 1'b0;
    #1;
    chk("R11 all squashed", free_cnt, 8);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ins_valid = 0; ins_seq = '0; ins_addr = '0; ins_size = '0; ins_data = '0;
    ins_cond = 0; ins_uncached = 0; ins_prefetch = 0; ins_fault = 0;
    cmt_valid = 0; cmt_seq = '0; sqh_valid = 0; sqh_seq = '0; lock_flag = 0;
    req_ready = 2'b11; cache_retry = 0; rsp_valid = 0; rsp_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_commit_order();
    t_ports();
    t_blocked();
    t_zero_pf();
    t_sc();
    t_stop();
    t_squash();
    t_full();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule